// File: doc/BRIEF.md
# Interleaved Two-Bank Word Memory

This block is a single-port word memory assembled from two half-size banks. The least significant address bit picks the bank. The remaining address bits pick the row inside that bank. On each access only the addressed bank is enabled, so the other bank does no switching for that cycle.

A read returns its word one clock after the address is presented. A write returns the written word on the read port one clock later, because the bank output register is loaded on writes too. The bank bit is captured on the access edge and drives the read-data multiplexer. The output therefore always follows the bank that was accessed last.

Each bank has an access counter that exists for test, so that a bench can confirm that every access reached exactly one bank. The address width is a parameter. A 15-bit setting gives 32K words built from two 16K banks. The default is kept small so that elaboration stays light.

Top module: `split_mem`

## Requirements
- R1: An access (`acc_en`=1) with `addr[0]`=0 enables only the even bank, and with `addr[0]`=1 only the odd bank. Exactly one of `hits_even`/`hits_odd` increments by one per access.
- R2: A read (`acc_en`=1, `wr_en`=0) presents the word last written at that address on `rdata` in the following cycle.
- R3: A write changes only the word at its own address. The word at the neighbouring address in the other bank, and other rows of the same bank, read back unchanged.
- R4: In the cycle after a write, `rdata` equals the written data.
- R5: While `acc_en`=0, no bank is enabled, `wr_en`, `addr` and `wdata` have no effect, `rdata` holds its value and both counters hold.
- R6: A synchronous reset (`rst_n`=0 at a clock edge) clears `rdata` and both counters to zero.
- R7: The counters wrap from 2^CNT_W-1 to 0.
- R8: With back-to-back accesses that alternate between banks, `rdata` in each cycle comes from the bank accessed in the previous cycle.
- R9: The highest address (all ones) and address zero are both stored and returned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access enable |
| wr_en | input | 1 | Write strobe, sent to both banks |
| addr | input | ADDR_W | Word address; bit 0 selects the bank |
| wdata | input | DATA_W | Write data, sent to both banks |
| rdata | output | DATA_W | Read data, one-cycle latency |
| hits_even | output | CNT_W | Access count of the even bank |
| hits_odd | output | CNT_W | Access count of the odd bank |

## Verification
The bench goes after the alternating-bank pattern. A multiplexer steered by the live address bit instead of the registered one would show the wrong bank's word in that pattern. It writes adjacent even/odd pairs and rereads the neighbour, which exposes a write strobe that reaches both banks. It drives idle cycles with the write strobe high and garbage addresses, which catches a design whose bank enables or select register ignore the access enable. It runs one counter through its wrap, and it covers the first and last address, where a wrong row slice would alias.

// File: rtl/split_mem_pkg.sv
// Shared types for the interleaved two-bank memory.
// Assumes bank index equals the least significant address bit.
package split_mem_pkg;
    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_id_t;

    localparam int NUM_BANKS = 2;

    // Map the low address bit onto a bank identifier.
    function automatic bank_id_t bank_of(input logic lsb);
        return bank_id_t'(lsb);
    endfunction
endpackage

// File: rtl/sm_bank.sv
// One behavioural half-size bank with a registered output.
// Assumes: the array is only touched when en is high; on a write the
// output register takes the write data (write-through).
module sm_bank #(
    parameter int ROW_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] arr [DEPTH];

    // Store write data into the addressed row when enabled.
    always_ff @(posedge clk) begin
        if (en && we) begin
            arr[row] <= wdata;
        end
    end

    // Load the output register on any enabled access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= we ? wdata : arr[row];
        end
    end
endmodule

// File: rtl/sm_hitcnt.sv
// Wrapping access counter for one bank, kept for test visibility.
// Assumes inc is high for exactly the cycles the bank is enabled.
module sm_hitcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    // Count enabled cycles, wrapping at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/split_mem.sv
// Word memory interleaved across two half-size banks by addr[0].
// Only the addressed bank is enabled per access; a registered copy of
// the bank bit steers the read multiplexer. Assumes ADDR_W >= 2.
module split_mem
    import split_mem_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  hits_even,
    output logic [CNT_W-1:0]  hits_odd
);
    localparam int ROW_W = ADDR_W - 1;

    logic [NUM_BANKS-1:0] bank_en;
    logic [DATA_W-1:0]    bank_q   [NUM_BANKS];
    logic [CNT_W-1:0]     bank_cnt [NUM_BANKS];
    logic [ROW_W-1:0]     row;
    bank_id_t             sel_q;

    assign row = addr[ADDR_W-1:1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Enable a bank only when it owns the low address bit.
        assign bank_en[b] = acc_en && (bank_of(addr[0]) == bank_id_t'(b));

        sm_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[b]),
            .we    (wr_en),
            .row   (row),
            .wdata (wdata),
            .q     (bank_q[b])
        );

        sm_hitcnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (bank_en[b]),
            .cnt   (bank_cnt[b])
        );
    end

    // Capture the bank bit on each access; hold it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= BANK_EVEN;
        end else if (acc_en) begin
            sel_q <= bank_of(addr[0]);
        end
    end

    // Steer read data from the bank accessed last.
    assign rdata     = bank_q[sel_q];
    assign hits_even = bank_cnt[BANK_EVEN];
    assign hits_odd  = bank_cnt[BANK_ODD];
endmodule

// File: rtl/split_mem_chk.sv
// Property checker for split_mem, attached by bind below.
// Assumes reset is held low during the first clock edges.
module split_mem_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [CNT_W-1:0]  hits_even,
    input logic [CNT_W-1:0]  hits_odd,
    input logic [1:0]        bank_en
);
    p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> ($countones(bank_en) == 1 && bank_en[addr[0]]));

    p_even_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !addr[0]) |=>
            (hits_even == CNT_W'($past(hits_even) + 1'b1)) && $stable(hits_odd));

    p_odd_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && addr[0]) |=>
            (hits_odd == CNT_W'($past(hits_odd) + 1'b1)) && $stable(hits_even));

    p_write_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr_en) |=> (rdata == $past(wdata)));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> ($stable(rdata) && $stable(hits_even) && $stable(hits_odd)));

    p_idle_no_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (bank_en == 2'b00));
endmodule

bind split_mem split_mem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_split_mem_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .hits_even (hits_even),
    .hits_odd  (hits_odd),
    .bank_en   (bank_en)
);

// File: tb/split_mem_bench.sv
// Bench for split_mem: a behavioural reference model updated on each
// rising edge, compared against the outputs on each falling edge.
module split_mem_bench;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [CNT_W-1:0]  hits_even;
    logic [CNT_W-1:0]  hits_odd;

    int checks = 0;
    int failures = 0;
    string cur_req = "R6";
    bit done = 1'b0;

    // Reference model state
    logic [DATA_W-1:0] ref_mem [DEPTH];
    logic [DATA_W-1:0] exp_rd = '0;
    int                exp_even = 0;
    int                exp_odd = 0;

    always #4 clk = ~clk;   // 125 MHz

    split_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_split_mem (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .hits_even(hits_even), .hits_odd(hits_odd)
    );

    // Model: one logical memory, latency one, counters per address parity.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_rd = '0; exp_even = 0; exp_odd = 0;
        end else if (acc_en) begin
            if (wr_en) begin
                ref_mem[addr] = wdata;
                exp_rd = wdata;
            end else begin
                exp_rd = ref_mem[addr];
            end
            if (addr[0]) exp_odd = (exp_odd + 1) % (1 << CNT_W);
            else         exp_even = (exp_even + 1) % (1 << CNT_W);
        end
    end

    task automatic check(input string what, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (!done && $time > 20) begin
            check("rdata", rdata, exp_rd);
            check("hits_even", DATA_W'(hits_even), DATA_W'(exp_even));
            check("hits_odd", DATA_W'(hits_odd), DATA_W'(exp_odd));
        end
    end

    task automatic drive(input logic en, input logic we,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        acc_en = en; wr_en = we; addr = a; wdata = d;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R6";                          // R6: reset values seen by compare
        drive(1'b0, 1'b0, '0, '0);
        drive(1'b0, 1'b0, '0, '0);

        cur_req = "R4";                          // R4/R1: writes alternate banks
        for (int i = 0; i < 16; i++) drive(1'b1, 1'b1, ADDR_W'(i), 32'hA500_0000 + 32'(i * 17));

        cur_req = "R8";                          // R8/R2: alternating reads
        for (int i = 0; i < 16; i++) drive(1'b1, 1'b0, ADDR_W'(i), '0);
        for (int i = 15; i >= 0; i--) drive(1'b1, 1'b0, ADDR_W'(i), '0);

        cur_req = "R3";                          // R3: rewrite 4, neighbours intact
        drive(1'b1, 1'b1, ADDR_W'(4), 32'hDEAD_BEEF);
        drive(1'b1, 1'b0, ADDR_W'(5), '0);
        drive(1'b1, 1'b0, ADDR_W'(6), '0);
        drive(1'b1, 1'b0, ADDR_W'(4), '0);
        drive(1'b1, 1'b1, ADDR_W'(7), 32'h1234_5678);
        drive(1'b1, 1'b0, ADDR_W'(6), '0);
        drive(1'b1, 1'b0, ADDR_W'(7), '0);

        cur_req = "R5";                          // R5: idle with garbage, strobe high
        drive(1'b1, 1'b0, ADDR_W'(3), '0);
        for (int i = 0; i < 8; i++) drive(1'b0, 1'b1, ADDR_W'(i), 32'hFFFF_0000 | 32'(i));
        drive(1'b1, 1'b0, ADDR_W'(2), '0);
        drive(1'b0, 1'b1, ADDR_W'(3), 32'h0BAD_0BAD);
        drive(1'b0, 1'b0, ADDR_W'(1), '0);
        drive(1'b1, 1'b0, ADDR_W'(3), '0);

        cur_req = "R9";                          // R9: address extremes
        drive(1'b1, 1'b1, '1, 32'hCAFE_F00D);
        drive(1'b1, 1'b1, '0, 32'h0000_0001);
        drive(1'b1, 1'b0, '1, '0);
        drive(1'b1, 1'b0, '0, '0);
        drive(1'b1, 1'b0, ADDR_W'(DEPTH - 2), '0);

        cur_req = "R2";                          // R2: reads after mixed traffic
        drive(1'b1, 1'b0, ADDR_W'(9), '0);
        drive(1'b1, 1'b0, ADDR_W'(8), '0);

        cur_req = "R7";                          // R7: odd counter wraps
        for (int i = 0; i < (1 << CNT_W) + 4; i++) drive(1'b1, 1'b0, ADDR_W'(1), '0);
        drive(1'b0, 1'b0, '0, '0);

        cur_req = "R6";                          // R6: reset mid-run clears outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drive(1'b0, 1'b0, '0, '0);
        drive(1'b0, 1'b0, '0, '0);
        cur_req = "R1";                          // R1: single odd access after reset
        drive(1'b1, 1'b0, ADDR_W'(1), '0);
        drive(1'b0, 1'b0, '0, '0);
        @(negedge clk);
        finish_run();
    end
endmodule